// File: doc/BRIEF.md
# Channel Epoch Counter Pair with Tic Capture

This block keeps code-period timing for one correlator channel. A short counter advances once per dump pulse and runs from 0 to 19. When it wraps it advances a long counter, which runs from 0 to 49 and so counts bit intervals of twenty periods. On every measurement tic the block copies both counters into a held word that software reads as the epoch stamp of that tic. The live word shows the counters as they run and changes with every dump.

Software sets the counters through a load strobe and a 16-bit load word. The mode bit chooses when a load takes effect. In update mode the load takes effect at once. In preset mode the block keeps the written values pending. It arms itself when the strobe falls and applies the pending values at the next tic, so that many channels can be aligned on one common tic. The load word, the live word and the held word all use the same packed layout.

Top module: `chan_epoch_timer`

## Requirements
- R1: After reset both counters are 0, the held word is 0 and no preset load is armed.
- R2: The live and held words place the short counter in bits 4:0 and the long counter in bits 13:8. Bits 15, 14, 7, 6 and 5 read 0. A load uses the same positions, and load bits outside those fields are ignored.
- R3: Each dump advances the short counter. When the short counter is at 19 or above, a dump sets it to 0 and advances the long counter. When the long counter is at 49 or above, that step sets it to 0.
- R4: The live word is not latched. It shows the new count in the cycle after each dump and stays unchanged in cycles with no dump, load or applied preset.
- R5: In update mode (mode bit 0), each cycle with the load strobe high writes the word's fields into the counters, visible the next cycle. A dump in the same cycle is ignored.
- R6: A tic copies the counter values of its own cycle into the held word. Those are the values from before any dump, update load or preset load in the same cycle. The held word changes only on tics.
- R7: In preset mode (mode bit 1), the load strobe leaves the counters unchanged. The pending value is the word present in the last strobe-high cycle. The preset is armed from the cycle after the strobe falls, so a tic while the strobe is high, or in the cycle it falls, applies nothing.
- R8: An armed preset loads the pending values into the counters at the next tic and takes priority over a dump in that cycle. That tic disarms it, so later tics capture without loading.
- R9: If an update-mode load and an armed tic fall in the same cycle, the update load's values win and the preset is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dump_i | input | 1 | Code-period dump pulse |
| tic_i | input | 1 | Measurement tic pulse |
| preset_mode_i | input | 1 | 0 = update (immediate) loading, 1 = preset (tic-deferred) loading |
| load_stb_i | input | 1 | Load write strobe |
| load_data_i | input | 16 | Packed load word |
| live_word_o | output | 16 | Running counter values, packed |
| held_word_o | output | 16 | Counter values captured at the last tic, packed |

## Verification
Two pairs of events can land in one cycle: a tic with a dump, and a load with a dump. An armed preset tic with an update load is a third. Directed sequences put a tic on the same edge as a dump and an update load on the same edge as a dump. They also place a tic in the strobe-high cycle, in the falling-edge cycle and in the first armed cycle. Random stimulus then overlaps all these pulses freely. A bench model checks that the held word always shows the pre-edge counts and that the loaded values beat the dump step.

// File: rtl/epoch_pkg.sv
package epoch_pkg;
   localparam int WORD_W       = 16;
   localparam int SHORT_MOD_D  = 20;
   localparam int LONG_MOD_D   = 50;
   localparam int SHORT_W_D    = 5;
   localparam int LONG_W_D     = 6;
   localparam int LONG_LSB_D   = 8;

   typedef logic [WORD_W-1:0] epoch_word_t;
endpackage

// File: rtl/epoch_mod_counter.sv
module epoch_mod_counter #(
   parameter int MOD = 20,
   parameter int W   = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         adv_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);
   localparam logic [W-1:0] LAST = W'(MOD - 1);

   initial begin
      assert (MOD >= 2 && MOD <= (1 << W))
         else $error("epoch_mod_counter: MOD must fit in W bits");
   end

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_next;
   logic         at_last;

   generate
      if (MOD == (1 << W)) begin : g_pow2
         assign at_last  = &cnt_q;
         assign cnt_next = cnt_q + 1'b1;
      end else begin : g_cmp
         assign at_last  = (cnt_q >= LAST);
         assign cnt_next = at_last ? '0 : cnt_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (adv_i)  cnt_q <= cnt_next;
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = adv_i & at_last;

   assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i && cnt_o == LAST) |=> (cnt_o == '0));
   assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !load_i) |=> $stable(cnt_o));
endmodule

// File: rtl/epoch_preset_arm.sv
module epoch_preset_arm #(
   parameter int SW = 5,
   parameter int LW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          preset_mode_i,
   input  logic          stb_i,
   input  logic [SW-1:0] sht_i,
   input  logic [LW-1:0] lng_i,
   input  logic          apply_i,
   output logic [SW-1:0] pend_sht_o,
   output logic [LW-1:0] pend_lng_o,
   output logic          armed_o
);
   logic          stb_prev_q;
   logic          armed_q;
   logic [SW-1:0] pend_sht_q;
   logic [LW-1:0] pend_lng_q;
   logic          fall;

   assign fall = stb_prev_q & ~stb_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb_prev_q <= 1'b0;
         armed_q    <= 1'b0;
         pend_sht_q <= '0;
         pend_lng_q <= '0;
      end else begin
         stb_prev_q <= stb_i & preset_mode_i;
         if (stb_i && preset_mode_i) begin
            pend_sht_q <= sht_i;
            pend_lng_q <= lng_i;
         end
         if (fall)         armed_q <= 1'b1;
         else if (apply_i) armed_q <= 1'b0;
      end
   end

   assign pend_sht_o = pend_sht_q;
   assign pend_lng_o = pend_lng_q;
   assign armed_o    = armed_q;

   assert_arm_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_prev_q && !stb_i) |=> armed_o);
   assert_disarm_on_apply_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (apply_i && !(stb_prev_q && !stb_i)) |=> !armed_o);
endmodule

// File: rtl/epoch_tic_hold.sv
module epoch_tic_hold #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tic_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     q_q <= '0;
      else if (tic_i) q_q <= d_i;
   end

   assign q_o = q_q;
endmodule

// File: rtl/chan_epoch_timer.sv
module chan_epoch_timer
   import epoch_pkg::*;
#(
   parameter int SHORT_MOD = SHORT_MOD_D,
   parameter int LONG_MOD  = LONG_MOD_D,
   parameter int SHORT_W   = SHORT_W_D,
   parameter int LONG_W    = LONG_W_D,
   parameter int LONG_LSB  = LONG_LSB_D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dump_i,
   input  logic              tic_i,
   input  logic              preset_mode_i,
   input  logic              load_stb_i,
   input  logic [WORD_W-1:0] load_data_i,
   output logic [WORD_W-1:0] live_word_o,
   output logic [WORD_W-1:0] held_word_o
);
   localparam epoch_word_t SHORT_MASK = epoch_word_t'((1 << SHORT_W) - 1);
   localparam epoch_word_t LONG_MASK  = epoch_word_t'(((1 << LONG_W) - 1) << LONG_LSB);
   localparam epoch_word_t FIELD_MASK = SHORT_MASK | LONG_MASK;

   initial begin
      assert (LONG_LSB >= SHORT_W)
         else $error("chan_epoch_timer: fields overlap");
      assert (LONG_LSB + LONG_W <= WORD_W)
         else $error("chan_epoch_timer: long field exceeds word");
   end

   logic [SHORT_W-1:0] sht_cnt, sht_load, pend_sht, wr_sht;
   logic [LONG_W-1:0]  lng_cnt, lng_load, pend_lng, wr_lng;
   logic               sht_wrap, lng_wrap_unused;
   logic               upd_load, armed, apply, cnt_load;
   epoch_word_t        live_w;
   logic               unused_bits;

   assign wr_sht      = load_data_i[SHORT_W-1:0];
   assign wr_lng      = load_data_i[LONG_LSB +: LONG_W];
   assign unused_bits = ^(load_data_i & ~FIELD_MASK);

   assign upd_load = load_stb_i & ~preset_mode_i;
   assign apply    = tic_i & armed;
   assign cnt_load = upd_load | apply;
   assign sht_load = upd_load ? wr_sht : pend_sht;
   assign lng_load = upd_load ? wr_lng : pend_lng;

   epoch_preset_arm #(.SW(SHORT_W), .LW(LONG_W)) u_arm (
      .clk           (clk),
      .rst_n         (rst_n),
      .preset_mode_i (preset_mode_i),
      .stb_i         (load_stb_i),
      .sht_i         (wr_sht),
      .lng_i         (wr_lng),
      .apply_i       (apply),
      .pend_sht_o    (pend_sht),
      .pend_lng_o    (pend_lng),
      .armed_o       (armed)
   );

   epoch_mod_counter #(.MOD(SHORT_MOD), .W(SHORT_W)) u_short (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_i      (dump_i),
      .load_i     (cnt_load),
      .load_val_i (sht_load),
      .cnt_o      (sht_cnt),
      .wrap_o     (sht_wrap)
   );

   epoch_mod_counter #(.MOD(LONG_MOD), .W(LONG_W)) u_long (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_i      (sht_wrap),
      .load_i     (cnt_load),
      .load_val_i (lng_load),
      .cnt_o      (lng_cnt),
      .wrap_o     (lng_wrap_unused)
   );

   always_comb begin
      live_w                      = '0;
      live_w[SHORT_W-1:0]         = sht_cnt;
      live_w[LONG_LSB +: LONG_W]  = lng_cnt;
   end

   epoch_tic_hold #(.W(WORD_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .tic_i (tic_i),
      .d_i   (live_w),
      .q_o   (held_word_o)
   );

   assign live_word_o = live_w;

   assert_tic_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tic_i |=> (held_word_o == $past(live_word_o)));
   assert_held_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !tic_i |=> $stable(held_word_o));
   assert_update_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb_i && !preset_mode_i) |=> (live_word_o == ($past(load_data_i) & FIELD_MASK)));
   assert_preset_defers_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (preset_mode_i && load_stb_i && !tic_i && !dump_i) |=> $stable(live_word_o));
   assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((live_word_o & ~FIELD_MASK) == '0) && ((held_word_o & ~FIELD_MASK) == '0));
endmodule

// File: tb/chan_epoch_timer_bench.sv
`timescale 1ns/1ps
module chan_epoch_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dump_i = 1'b0, tic_i = 1'b0, preset_mode_i = 1'b0, load_stb_i = 1'b0;
   logic [15:0] load_data_i = '0;
   logic [15:0] live_word_o, held_word_o;

   int tests = 0;
   int fails = 0;

   // model state
   int          m_s = 0, m_l = 0, m_ps = 0, m_pl = 0;
   bit          m_armed = 0, m_stbq = 0;
   logic [15:0] m_held = '0;

   always #2 clk = ~clk;

   chan_epoch_timer u_chan_epoch_timer (
      .clk(clk), .rst_n(rst_n), .dump_i(dump_i), .tic_i(tic_i),
      .preset_mode_i(preset_mode_i), .load_stb_i(load_stb_i),
      .load_data_i(load_data_i), .live_word_o(live_word_o), .held_word_o(held_word_o)
   );

   function automatic logic [15:0] pk(int s, int l);
      logic [15:0] w = '0;
      w[4:0]  = 5'(s);
      w[13:8] = 6'(l);
      return w;
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // advance model by one edge using the inputs applied before it
   task automatic model_step(bit d, bit t, bit m, bit st, logic [15:0] dat);
      bit upd, app, fall;
      upd  = st && !m;
      app  = t && m_armed;
      fall = m_stbq && !st;
      if (t) m_held = pk(m_s, m_l);
      if (upd) begin
         m_s = dat[4:0]; m_l = dat[13:8];
      end else if (app) begin
         m_s = m_ps; m_l = m_pl;
      end else if (d) begin
         if (m_s >= 19) begin
            m_s = 0;
            m_l = (m_l >= 49) ? 0 : m_l + 1;
         end else m_s++;
      end
      if (st && m) begin m_ps = dat[4:0]; m_pl = dat[13:8]; end
      if (fall) m_armed = 1;
      else if (app) m_armed = 0;
      m_stbq = st && m;
   endtask

   task automatic cyc(bit d, bit t, bit m, bit st, logic [15:0] dat, string tag);
      dump_i = d; tic_i = t; preset_mode_i = m; load_stb_i = st; load_data_i = dat;
      @(negedge clk);
      model_step(d, t, m, st, dat);
      check({tag, " live"}, live_word_o, pk(m_s, m_l));
      check({tag, " held"}, held_word_o, m_held);
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 live", live_word_o, 16'h0000);
      check("R1 held", held_word_o, 16'h0000);

      // R4: dumps count, idle holds
      cyc(1, 0, 0, 0, 0, "R4");
      cyc(1, 0, 0, 0, 0, "R4");
      check("R4 after two dumps", live_word_o, 16'h0002);
      cyc(0, 0, 0, 0, 0, "R4");
      check("R4 idle", live_word_o, 16'h0002);

      // R5/R3: load 19/49 and wrap both
      cyc(0, 0, 0, 1, 16'h3113, "R5");
      check("R5 immediate", live_word_o, 16'h3113);
      cyc(1, 0, 0, 0, 0, "R3");
      check("R3 double wrap", live_word_o, 16'h0000);
      cyc(0, 0, 0, 1, 16'h0013, "R5");
      cyc(1, 0, 0, 0, 0, "R3");
      check("R3 carry", live_word_o, 16'h0100);

      // R2: junk bits masked, out-of-range wraps
      cyc(0, 0, 0, 1, 16'hFFFF, "R2");
      check("R2 mask", live_word_o, 16'h3F1F);
      cyc(1, 0, 0, 0, 0, "R3");
      check("R3 out of range", live_word_o, 16'h0000);

      // R5: load beats dump
      cyc(1, 0, 0, 1, 16'h0005, "R5");
      check("R5 load over dump", live_word_o, 16'h0005);

      // R6: tic with dump captures pre-dump value
      cyc(1, 1, 0, 0, 0, "R6");
      check("R6 held pre-dump", held_word_o, 16'h0005);
      check("R6 live", live_word_o, 16'h0006);

      // R7/R8: preset sequence
      cyc(0, 1, 1, 1, 16'h0703, "R7");
      cyc(0, 0, 1, 1, 16'h0A04, "R7");
      check("R7 no change", live_word_o, 16'h0006);
      cyc(0, 1, 1, 0, 0, "R7");
      check("R7 tic on fall", live_word_o, 16'h0006);
      cyc(1, 1, 1, 0, 0, "R8");
      check("R8 applied", live_word_o, 16'h0A04);
      check("R8 held pre-load", held_word_o, 16'h0006);
      cyc(0, 1, 1, 0, 0, "R8");
      check("R8 disarmed", live_word_o, 16'h0A04);
      check("R8 held", held_word_o, 16'h0A04);

      // R9: update load and armed tic together
      cyc(0, 0, 1, 1, 16'h0102, "R9");
      cyc(0, 0, 1, 0, 0, "R9");
      cyc(0, 1, 0, 1, 16'h0203, "R9");
      check("R9 update wins", live_word_o, 16'h0203);
      cyc(0, 1, 0, 0, 0, "R9");
      check("R9 consumed", live_word_o, 16'h0203);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         bit d, t, m, st;
         logic [15:0] dat;
         d   = ($urandom % 2) == 0;
         t   = ($urandom % 6) == 0;
         m   = ($urandom % 3) != 0;
         st  = ($urandom % 5) == 0;
         dat = (($urandom % 4) == 0) ? 16'($urandom)
               : pk($urandom % 20, $urandom % 50);
         cyc(d, t, m, st, dat, "R3 R4 R6 R7 R8");
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule